// File: doc/BRIEF.md
# Serial Control Port for a Triple Half-Bridge Driver

This block is the 16-bit serial slave port of a three-phase half-bridge driver. A host selects the port with an active-low chip-select, clocks a control word in on the data-in line and reads a status word back on data-out in the same frame. Both directions run least significant bit first. When chip-select returns high after a complete frame, the port hands the new switch commands, the overcurrent-shutdown enable and a one-shot flag-clear request to the control logic. It does no fault detection and does not drive the power stages.

All serial pins are synchronised into the system clock and their edges are detected there, so the block lives in one clock domain. The status word is captured when chip-select falls, and its bit 0 (temperature prewarning) shows on data-out at once. A host can poll that flag by dropping chip-select and raising it again without clocking. Input and output share one shift register. Bits pushed in come out of data-out 16 clocks later, so several ports can be chained on one select line, and any frame whose length is a whole number of words is accepted.

Top module: `hbridge_serial_port`

## Requirements
- R1: While rst_ni is low and directly after reset: drive_o is 0, oc_shut_en_o is 1, update_o and flag_clr_o are 0, and sdo_oe_o is 0.
- R2: sdo_oe_o is 1 while cs_ni is low. It is 0 from at most four clock cycles after cs_ni goes high.
- R3: On the falling edge of cs_ni the status word is captured and bit 0 appears on sdo_o before any serial clock. Status layout: bit 0 temp_warn_i, bits 1..6 sw_state_i[0..5], bit 13 short_det_i, bit 14 open_load_i, bit 15 supply_fail_i, all other bits 0.
- R4: sdo_o changes only on a rising sclk_i edge that follows at least one falling edge in the frame. A rising edge before the first falling edge leaves bit 0 in place, so a host that samples before falling edge i reads status bit i.
- R5: sdi_i is sampled on falling sclk_i edges, first bit into bit 0. Word bits 1..6 set drive_o[0..5].
- R6: When cs_ni rises after N falling sclk_i edges, N a nonzero multiple of 16, drive_o and oc_shut_en_o (word bit 13) take the new word and update_o pulses high for exactly one cycle.
- R7: flag_clr_o pulses high together with update_o when word bit 0 is 1, and stays low otherwise.
- R8: A frame whose falling-edge count is not a nonzero multiple of 16 (including zero, as in a flag poll) changes no output and produces no pulse.
- R9: In frames longer than 16 bits, sdo_o before falling edge i (i >= 16) carries the sdi_i bit taken at edge i-16, and the word committed is the last 16 bits received.
- R10: Activity on sclk_i and sdi_i while cs_ni is high has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial chip-select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| temp_warn_i | input | 1 | Temperature prewarning flag |
| sw_state_i | input | 6 | Actual on/off state of the six switches |
| short_det_i | input | 1 | Short detected flag |
| open_load_i | input | 1 | Open load flag |
| supply_fail_i | input | 1 | Supply undervoltage flag |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Output enable for the data-out pad (0 = high impedance) |
| drive_o | output | 6 | Committed switch commands |
| oc_shut_en_o | output | 1 | Committed overcurrent-shutdown enable |
| flag_clr_o | output | 1 | One-cycle request to clear latched fault flags |
| update_o | output | 1 | One-cycle strobe on each commit |

## Verification
The bench targets frame length. It runs aborted frames of 9 and 17 bits and a zero-bit poll. A port that committed on any chip-select rise would corrupt the switch commands in these frames. A 32-bit chained frame checks that data-out replays data-in after 16 bits and that the last word wins. A port that counted exactly 16 would drop that frame. The first rising clock edge of each frame shows whether data-out shifts before any bit has been sampled. If it did, every status bit would read one position early. Clocking with chip-select high, and a reset in mid-run after the enable was cleared, show whether state leaks outside a frame and whether the enable really comes back high from reset.

// File: rtl/hbsp_pkg.sv
package hbsp_pkg;

  localparam int unsigned WORD_W  = 16;
  localparam int unsigned N_SW    = 6;

  // word bit positions decoded by the control logic
  localparam int unsigned CLR_POS = 0;
  localparam int unsigned SW_LSB  = 1;
  localparam int unsigned OCS_POS = 13;

  // status bit positions
  localparam int unsigned TW_POS  = 0;
  localparam int unsigned SC_POS  = 13;
  localparam int unsigned OL_POS  = 14;
  localparam int unsigned SF_POS  = 15;

  localparam logic OCS_RST = 1'b1;

  typedef struct packed {
    logic fall;
    logic rise;
  } edge_t;

  function automatic logic [WORD_W-1:0] pack_status(
    input logic            tw,
    input logic [N_SW-1:0] sw,
    input logic            sc,
    input logic            ol,
    input logic            sf
  );
    logic [WORD_W-1:0] w;
    w = '0;
    w[TW_POS]              = tw;
    w[SW_LSB +: N_SW]      = sw;
    w[SC_POS]              = sc;
    w[OL_POS]              = ol;
    w[SF_POS]              = sf;
    return w;
  endfunction

endpackage

// File: rtl/hbsp_sync.sv
module hbsp_sync #(
  parameter int unsigned   N       = 3,
  parameter int unsigned   STAGES  = 2,
  parameter logic [N-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] q_d_o
);

  for (genvar gi = 0; gi < N; gi++) begin : g_bit
    logic [STAGES:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= {(STAGES+1){RST_VAL[gi]}};
      else         pipe_q <= {pipe_q[STAGES-1:0], d_i[gi]};
    end
    assign q_o[gi]   = pipe_q[STAGES-1];
    assign q_d_o[gi] = pipe_q[STAGES];
  end

endmodule

// File: rtl/hbsp_framer.sv
module hbsp_framer #(
  parameter int unsigned WORD_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  hbsp_pkg::edge_t cs_e_i,
  input  hbsp_pkg::edge_t sclk_e_i,
  output logic            active_o,
  output logic            load_o,
  output logic            sample_o,
  output logic            shift_o,
  output logic            commit_o
);

  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic             active_q;
  logic [CNT_W-1:0] idx_q;
  logic             seen_q;
  logic             pend_q;

  assign load_o   = cs_e_i.fall;
  assign sample_o = active_q & sclk_e_i.fall;
  // a rising edge shifts only once a bit has been taken
  assign shift_o  = active_q & sclk_e_i.rise & pend_q;
  assign commit_o = active_q & cs_e_i.rise & seen_q & (idx_q == '0);
  assign active_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      seen_q   <= 1'b0;
      pend_q   <= 1'b0;
    end else if (cs_e_i.fall) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      seen_q   <= 1'b0;
      pend_q   <= 1'b0;
    end else if (cs_e_i.rise) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (sample_o) begin
        idx_q  <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
        seen_q <= 1'b1;
        pend_q <= 1'b1;
      end else if (shift_o) begin
        pend_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/hbsp_shifter.sv
module hbsp_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_val_i,
  input  logic              sample_i,
  input  logic              shift_i,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] word_o,
  output logic              sdo_o
);

  logic [WORD_W-1:0] sr_q;
  logic              dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      dout_q <= 1'b0;
    end else if (load_i) begin
      sr_q   <= load_val_i;
      dout_q <= load_val_i[0];
    end else begin
      if (sample_i) sr_q   <= {sdi_i, sr_q[WORD_W-1:1]};
      if (shift_i)  dout_q <= sr_q[0];
    end
  end

  assign word_o = sr_q;
  assign sdo_o  = dout_q;

endmodule

// File: rtl/hbridge_serial_port.sv
module hbridge_serial_port #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_ni,
  input  logic                    sclk_i,
  input  logic                    sdi_i,
  input  logic                    temp_warn_i,
  input  logic [hbsp_pkg::N_SW-1:0] sw_state_i,
  input  logic                    short_det_i,
  input  logic                    open_load_i,
  input  logic                    supply_fail_i,
  output logic                    sdo_o,
  output logic                    sdo_oe_o,
  output logic [hbsp_pkg::N_SW-1:0] drive_o,
  output logic                    oc_shut_en_o,
  output logic                    flag_clr_o,
  output logic                    update_o
);
  import hbsp_pkg::*;

  localparam int unsigned PIN_N  = 3;
  localparam int unsigned CS_B   = 0;
  localparam int unsigned SCLK_B = 1;
  localparam int unsigned SDI_B  = 2;

  logic [PIN_N-1:0] pins_q, pins_d;
  edge_t            cs_e, sclk_e;
  logic             active, load, sample, shift, commit;
  logic [WORD_W-1:0] word, status;
  logic             unused_bits;

  hbsp_sync #(
    .N      (PIN_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b001)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdi_i, sclk_i, cs_ni}),
    .q_o   (pins_q),
    .q_d_o (pins_d)
  );

  // chip-select is active low: its falling edge opens a frame
  assign cs_e.fall   =  pins_d[CS_B]   & ~pins_q[CS_B];
  assign cs_e.rise   = ~pins_d[CS_B]   &  pins_q[CS_B];
  assign sclk_e.fall =  pins_d[SCLK_B] & ~pins_q[SCLK_B];
  assign sclk_e.rise = ~pins_d[SCLK_B] &  pins_q[SCLK_B];

  hbsp_framer #(.WORD_W(WORD_W)) u_framer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_e_i  (cs_e),
    .sclk_e_i(sclk_e),
    .active_o(active),
    .load_o  (load),
    .sample_o(sample),
    .shift_o (shift),
    .commit_o(commit)
  );

  assign status = pack_status(temp_warn_i, sw_state_i, short_det_i,
                              open_load_i, supply_fail_i);

  hbsp_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(status),
    .sample_i  (sample),
    .shift_i   (shift),
    .sdi_i     (pins_q[SDI_B]),
    .word_o    (word),
    .sdo_o     (sdo_o)
  );

  assign sdo_oe_o = active;

  logic [N_SW-1:0] drive_q;
  logic            ocs_q, upd_q, clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_q <= '0;
      ocs_q   <= OCS_RST;
      upd_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      upd_q <= commit;
      clr_q <= commit & word[CLR_POS];
      if (commit) begin
        drive_q <= word[SW_LSB +: N_SW];
        ocs_q   <= word[OCS_POS];
      end
    end
  end

  assign drive_o      = drive_q;
  assign oc_shut_en_o = ocs_q;
  assign update_o     = upd_q;
  assign flag_clr_o   = clr_q;

  assign unused_bits = ^{word[WORD_W-1:OCS_POS+1], word[OCS_POS-1:SW_LSB+N_SW],
                         pins_d[SDI_B], pins_q[PIN_N-1:0]};

endmodule

// File: rtl/hbridge_serial_port_chk.sv
module hbridge_serial_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       sdo_o,
  input logic       sdo_oe_o,
  input logic [5:0] drive_o,
  input logic       oc_shut_en_o,
  input logic       flag_clr_o,
  input logic       update_o
);

  // R2
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3)) |-> !sdo_oe_o);

  // R6
  upd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o);

  // R6
  upd_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> $past(sdo_oe_o));

  // R7
  clr_with_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_o |-> update_o);

  // R8
  hold_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(drive_o) || !$stable(oc_shut_en_o)) |-> update_o);

  // R10
  idle_sdo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sdo_oe_o && $past(!sdo_oe_o)) |-> $stable(sdo_o));

endmodule

bind hbridge_serial_port hbridge_serial_port_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .sdo_o       (sdo_o),
  .sdo_oe_o    (sdo_oe_o),
  .drive_o     (drive_o),
  .oc_shut_en_o(oc_shut_en_o),
  .flag_clr_o  (flag_clr_o),
  .update_o    (update_o)
);

// File: tb/hbridge_serial_port_tb_top.sv
module hbridge_serial_port_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic tw = 1'b0, sc = 1'b0, ol = 1'b0, sf = 1'b0;
  logic [5:0] sw = '0;
  logic sdo, sdo_oe, ocs, clr, upd;
  logic [5:0] drive;

  always #10 clk = ~clk;

  hbridge_serial_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .temp_warn_i(tw), .sw_state_i(sw), .short_det_i(sc), .open_load_i(ol),
    .supply_fail_i(sf), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .drive_o(drive),
    .oc_shut_en_o(ocs), .flag_clr_o(clr), .update_o(upd)
  );

  int checks = 0, fails = 0, upd_cnt = 0, clr_cnt = 0;
  logic [5:0] exp_drive = '0;
  logic       exp_ocs = 1'b1;

  always @(negedge clk) begin
    if (upd) upd_cnt++;
    if (clr) clr_cnt++;
  end

  typedef struct packed {
    logic [31:0] data;
    logic [15:0] st;
    logic [5:0]  nbits;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{data: 32'h0000_207F, st: 16'h8001, nbits: 6'd16},
    '{data: 32'h0000_002A, st: 16'h6015, nbits: 6'd16},
    '{data: 32'h0000_FFFF, st: 16'h0002, nbits: 6'd9},
    '{data: 32'h0001_FFFE, st: 16'h2040, nbits: 6'd17},
    '{data: 32'h2054_5A3C, st: 16'hE07F, nbits: 6'd32},
    '{data: 32'h0000_0001, st: 16'h0000, nbits: 6'd16}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic apply_status(input logic [15:0] st);
    tw = st[0]; sw = st[6:1]; sc = st[13]; ol = st[14]; sf = st[15];
  endtask

  task automatic check_outputs(input string tag);
    chk({tag, " drive"}, 32'(drive), 32'(exp_drive));
    chk({tag, " ocs"}, 32'(ocs), 32'(exp_ocs));
  endtask

  task automatic run_frame(input logic [31:0] data, input int nbits, input logic [15:0] st);
    apply_status(st);
    cs_n = 1'b0;
    wait_clk(6);
    chk("R2 oe on", 32'(sdo_oe), 32'd1);
    for (int k = 0; k < nbits; k++) begin
      logic e;
      string tag;
      sdi  = data[k];
      sclk = 1'b1;
      wait_clk(6);
      e   = (k < 16) ? st[k] : data[k-16];
      tag = (k == 0) ? "R3 sdo bit0" : ((k < 16) ? "R4 sdo shift" : "R9 chain out");
      chk(tag, 32'(sdo), 32'(e));
      sclk = 1'b0;
      wait_clk(6);
    end
    cs_n = 1'b1;
    wait_clk(8);
    chk("R2 oe off", 32'(sdo_oe), 32'd0);
  endtask

  initial begin
    // R1 reset state
    wait_clk(3);
    chk("R1 drive", 32'(drive), 32'd0);
    chk("R1 ocs", 32'(ocs), 32'd1);
    chk("R1 update", 32'(upd), 32'd0);
    chk("R1 clr", 32'(clr), 32'd0);
    chk("R1 oe", 32'(sdo_oe), 32'd0);
    rst_n = 1'b1;
    wait_clk(4);

    for (int v = 0; v < NV; v++) begin
      int u0, c0, nb;
      logic [15:0] w;
      logic commit;
      u0 = upd_cnt; c0 = clr_cnt; nb = int'(VECS[v].nbits);
      run_frame(VECS[v].data, nb, VECS[v].st);
      commit = (nb != 0) && (nb % 16 == 0);
      if (commit) begin
        w = 16'(VECS[v].data >> (nb - 16));
        exp_drive = w[6:1];
        exp_ocs   = w[13];
        check_outputs(nb > 16 ? "R9 R5 R6 commit" : "R5 R6 commit");
        chk("R6 update pulse", 32'(upd_cnt - u0), 32'd1);
        chk("R7 clr pulse", 32'(clr_cnt - c0), 32'(w[0]));
      end else begin
        check_outputs("R8 ignored");
        chk("R8 no update", 32'(upd_cnt - u0), 32'd0);
        chk("R8 no clr", 32'(clr_cnt - c0), 32'd0);
      end
    end

    // R3 R8 flag poll without clocks
    for (int p = 0; p < 2; p++) begin
      int u0;
      u0 = upd_cnt;
      apply_status(p == 0 ? 16'h0001 : 16'h807E);
      cs_n = 1'b0;
      wait_clk(6);
      chk("R3 poll sdo", 32'(sdo), p == 0 ? 32'd1 : 32'd0);
      cs_n = 1'b1;
      wait_clk(8);
      check_outputs("R8 poll");
      chk("R8 poll no update", 32'(upd_cnt - u0), 32'd0);
    end

    // R10 clocking with chip-select high
    begin
      int u0;
      logic s0;
      u0 = upd_cnt; s0 = sdo;
      sdi = 1'b1;
      for (int k = 0; k < 16; k++) begin
        sclk = 1'b1; wait_clk(4);
        sclk = 1'b0; wait_clk(4);
      end
      wait_clk(6);
      check_outputs("R10 idle clocks");
      chk("R10 no update", 32'(upd_cnt - u0), 32'd0);
      chk("R10 sdo held", 32'(sdo), 32'(s0));
      chk("R10 oe low", 32'(sdo_oe), 32'd0);
    end

    // R1 reset in mid-run after a commit that cleared overcurrent enable
    chk("R1 pre-reset ocs", 32'(ocs), 32'd0);
    rst_n = 1'b0;
    wait_clk(2);
    chk("R1 mid drive", 32'(drive), 32'd0);
    chk("R1 mid ocs", 32'(ocs), 32'd1);
    chk("R1 mid oe", 32'(sdo_oe), 32'd0);
    rst_n = 1'b1;
    exp_drive = '0; exp_ocs = 1'b1;
    wait_clk(4);
    run_frame(32'h0000_0054, 16, 16'h4000);
    exp_drive = 6'b101010; exp_ocs = 1'b0;
    check_outputs("R5 after reset");

    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

endmodule